// File: doc/BRIEF.md
# Bounded Interrupt-Mask Window Monitor

This block sits next to a small processor core and carries out a bounded interrupt-disable instruction. Untrusted code can ask for the global interrupt gate to be closed for Y cycles. After that window the gate reopens by itself, and nothing the untrusted code does can stretch the window. Trusted code sets the largest allowed window once, in a limit register that untrusted code cannot change. A request above the limit is cut down to the limit and also raises a one-cycle security panic.

A new request is dropped while a window is running or while one is waiting. If an interrupt is pending when a request arrives, the interrupt is served first. The request is held and the window opens once the pending flag clears, which is after the handler has returned. The ordinary unbounded disable is only allowed in trusted mode, where it holds the gate shut until a trusted enable. From untrusted code it changes nothing and raises a panic. The panic output is not gated by the interrupt-enable output, so the core can route it as a non-maskable top-priority interrupt.

Top module: `atomic_window_mon`

## Requirements
- R1: An untrusted bounded-disable strobe with length Y, where 1 <= Y <= limit, that arrives with no window active and no interrupt pending drives `irq_en` low for the Y cycles after the strobe's clock edge. `irq_en` is high again in cycle Y+1, and no panic is raised.
- R2: A bounded-disable strobe with Y = 0 has no effect: `irq_en` stays high and no panic is raised.
- R3: An untrusted request with Y greater than the limit masks interrupts for exactly `limit` cycles. `panic` is high for one cycle only, the cycle after the strobe.
- R4: A bounded-disable strobe that arrives while a window is running or held is ignored, so the end of the first window does not move.
- R5: A request that arrives while `irq_pending` is high is held with `irq_en` still high. Its window starts in the cycle after `irq_pending` is seen low and lasts its full length.
- R6: An untrusted plain-disable strobe raises `panic` for one cycle and leaves `irq_en` unchanged.
- R7: A trusted plain-disable strobe holds `irq_en` low with no time limit until a trusted plain-enable strobe. A plain-enable strobe from untrusted code is ignored.
- R8: A bounded-disable request made in trusted mode uses its full length with no clamp and raises no panic.
- R9: The limit register resets to LIMIT_RST (default 8). It is written only when `lim_we` is high with `trusted` high. A write attempt from untrusted code leaves the limit unchanged.
- R10: After reset `irq_en` is high, `panic` is low and no window is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trusted | input | 1 | High while trusted-domain code is executing |
| lim_we | input | 1 | Write strobe for the limit register |
| lim_val | input | W | New limit value |
| bdis_stb | input | 1 | Bounded-disable instruction decoded |
| bdis_len | input | W | Requested window length Y |
| irq_pending | input | 1 | An interrupt is pending or being serviced |
| pdis_stb | input | 1 | Plain unbounded disable decoded |
| pen_stb | input | 1 | Plain enable decoded |
| irq_en | output | 1 | Global interrupt enable gate |
| panic | output | 1 | One-cycle security panic pulse |

## Verification
The properties assume that `trusted` is level-accurate in the cycle of each strobe. They also assume that `irq_pending` falls only when the handler has really returned, because a held request launches on that fall. The stimulus changes all inputs half a cycle away from the sampling edge and holds each strobe for exactly one cycle. It asserts `irq_pending` only across the held-request scenarios. The clamp property compares against the limit of the strobe cycle, so the bench never rewrites the limit while a request is in flight.

// File: rtl/amon_pkg.sv
package amon_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_HOLD = 2'd1,
    WIN_RUN  = 2'd2
  } win_state_e;
endpackage

// File: rtl/amon_limit_reg.sv
module amon_limit_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trusted,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] limit
);
  // Only the trusted domain may change the cap.
  always_ff @(posedge clk) begin
    if (rst) limit <= RST_VAL;
    else if (wr_en && trusted) limit <= wr_val;
  end
endmodule

// File: rtl/amon_req_check.sv
module amon_req_check #(
  parameter int W = 8
) (
  input  logic         trusted,
  input  logic         bdis_stb,
  input  logic [W-1:0] bdis_len,
  input  logic [W-1:0] limit,
  input  logic         pdis_stb,
  output logic         req_valid,
  output logic [W-1:0] eff_len,
  output logic         over_limit,
  output logic         bad_pdis
);
  logic too_long;

  always_comb begin
    too_long   = bdis_len > limit;
    // Trusted requests bypass the cap.
    eff_len    = (too_long && !trusted) ? limit : bdis_len;
    over_limit = bdis_stb && too_long && !trusted;
    req_valid  = bdis_stb && (eff_len != '0);
    bad_pdis   = pdis_stb && !trusted;
  end
endmodule

// File: rtl/amon_window.sv
module amon_window
  import amon_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [W-1:0] req_len,
  input  logic         irq_pending,
  output win_state_e   state,
  output logic [W-1:0] cnt,
  output logic         busy
);
  logic [W-1:0] hold_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WIN_IDLE;
      cnt      <= '0;
      hold_len <= '0;
    end else begin
      unique case (state)
        WIN_IDLE: begin
          if (req_valid) begin
            if (irq_pending) begin
              // Pending interrupt goes first; park the request.
              state    <= WIN_HOLD;
              hold_len <= req_len;
            end else begin
              state <= WIN_RUN;
              cnt   <= req_len;
            end
          end
        end
        WIN_HOLD: begin
          // Further requests are dropped here.
          if (!irq_pending) begin
            state <= WIN_RUN;
            cnt   <= hold_len;
          end
        end
        WIN_RUN: begin
          // Further requests are dropped here.
          if (cnt <= W'(1)) begin
            state <= WIN_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - W'(1);
          end
        end
        default: begin
          state <= WIN_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy = (state == WIN_RUN);
endmodule

// File: rtl/atomic_window_mon.sv
module atomic_window_mon
  import amon_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] LIMIT_RST = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trusted,
  input  logic         lim_we,
  input  logic [W-1:0] lim_val,
  input  logic         bdis_stb,
  input  logic [W-1:0] bdis_len,
  input  logic         irq_pending,
  input  logic         pdis_stb,
  input  logic         pen_stb,
  output logic         irq_en,
  output logic         panic
);
  logic [W-1:0] limit_q;
  logic         req_valid;
  logic [W-1:0] eff_len;
  logic         over_limit;
  logic         bad_pdis;
  win_state_e   win_state;
  logic [W-1:0] win_cnt;
  logic         win_busy;
  logic         plain_off;
  logic         panic_q;

  amon_limit_reg #(.W(W), .RST_VAL(LIMIT_RST)) u_lim (
    .clk(clk), .rst(rst), .trusted(trusted),
    .wr_en(lim_we), .wr_val(lim_val), .limit(limit_q)
  );

  amon_req_check #(.W(W)) u_chk_req (
    .trusted(trusted), .bdis_stb(bdis_stb), .bdis_len(bdis_len),
    .limit(limit_q), .pdis_stb(pdis_stb), .req_valid(req_valid),
    .eff_len(eff_len), .over_limit(over_limit), .bad_pdis(bad_pdis)
  );

  amon_window #(.W(W)) u_win (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(eff_len),
    .irq_pending(irq_pending), .state(win_state), .cnt(win_cnt),
    .busy(win_busy)
  );

  // Unbounded mask, available to the trusted domain only.
  always_ff @(posedge clk) begin
    if (rst) plain_off <= 1'b0;
    else if (trusted && pdis_stb) plain_off <= 1'b1;
    else if (trusted && pen_stb) plain_off <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) panic_q <= 1'b0;
    else panic_q <= over_limit | bad_pdis;
  end

  assign irq_en = !(win_busy || plain_off);
  assign panic  = panic_q;
endmodule

// File: rtl/amon_chk.sv
module amon_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         trusted,
  input logic         bdis_stb,
  input logic [W-1:0] bdis_len,
  input logic         irq_pending,
  input logic         pdis_stb,
  input logic         irq_en,
  input logic         panic,
  input logic [1:0]   state,
  input logic [W-1:0] cnt,
  input logic [W-1:0] limit,
  input logic         plain_off
);
  // R1
  run_masks_chk: assert property (@(posedge clk) disable iff (rst)
    state == 2'd2 |-> !irq_en);

  // R4
  nest_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2 && cnt > W'(1) && bdis_stb) |=>
      (state == 2'd2 && cnt == $past(cnt) - W'(1)));

  // R3
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && bdis_stb && !trusted && !irq_pending && bdis_len != '0) |=>
      (state == 2'd2 && cnt <= $past(limit)));

  // R5
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && bdis_stb && irq_pending && bdis_len != '0 && !plain_off) |=>
      (state == 2'd1 && irq_en));

  // R5
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1 && irq_pending) |=> state == 2'd1);

  // R6
  bad_pdis_chk: assert property (@(posedge clk) disable iff (rst)
    (pdis_stb && !trusted) |=> (panic && $stable(plain_off)));
endmodule

bind atomic_window_mon amon_chk #(.W(W)) u_amon_chk (
  .clk(clk), .rst(rst), .trusted(trusted), .bdis_stb(bdis_stb),
  .bdis_len(bdis_len), .irq_pending(irq_pending), .pdis_stb(pdis_stb),
  .irq_en(irq_en), .panic(panic), .state(win_state), .cnt(win_cnt),
  .limit(limit_q), .plain_off(plain_off)
);

// File: tb/sim_atomic_window_mon.sv
module sim_atomic_window_mon;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trusted = 1'b0, lim_we = 1'b0, bdis_stb = 1'b0, irq_pending = 1'b0;
  logic pdis_stb = 1'b0, pen_stb = 1'b0;
  logic [W-1:0] lim_val = '0, bdis_len = '0;
  logic irq_en, panic;

  always #10 clk = ~clk; // 50 MHz

  atomic_window_mon #(.W(W), .LIMIT_RST(8)) u0 (
    .clk(clk), .rst(rst), .trusted(trusted), .lim_we(lim_we), .lim_val(lim_val),
    .bdis_stb(bdis_stb), .bdis_len(bdis_len), .irq_pending(irq_pending),
    .pdis_stb(pdis_stb), .pen_stb(pen_stb), .irq_en(irq_en), .panic(panic)
  );

  typedef struct {
    int    cyc;
    bit    en;
    bit    pn;
    string req;
  } exp_t;

  exp_t sb[$];
  int ccount = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) ccount <= ccount + 1;

  // Monitor: pop every expectation due this cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= ccount) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (e.cyc != ccount || irq_en !== e.en || panic !== e.pn) begin
        n_bad++;
        $display("FAIL %s cyc %0d: irq_en=%b panic=%b, expected irq_en=%b panic=%b",
                 e.req, ccount, irq_en, panic, e.en, e.pn);
      end
    end
  end

  task automatic push(int off, bit en, bit pn, string r);
    exp_t e;
    e.cyc = ccount + off; e.en = en; e.pn = pn; e.req = r;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Bounded request with expectations; mask = cycles masked.
  task automatic bdis(bit tr, int y, int mask, bit pn, string r);
    @(negedge clk);
    trusted = tr; bdis_stb = 1'b1; bdis_len = W'(y);
    for (int k = 1; k <= mask; k++) push(k, 1'b0, (k == 1) ? pn : 1'b0, r);
    if (mask == 0) push(1, 1'b1, pn, r);
    push(mask + 1, 1'b1, (mask == 0) ? 1'b0 : 1'b0, r);
    push(mask + 2, 1'b1, 1'b0, r);
    @(negedge clk);
    bdis_stb = 1'b0; trusted = 1'b0;
    idle(mask + 3);
  endtask

  initial begin
    // R10 reset state
    idle(3);
    rst = 1'b0;
    push(1, 1'b1, 1'b0, "R10");
    push(2, 1'b1, 1'b0, "R10");
    idle(3);

    // R1 basic window
    bdis(1'b0, 3, 3, 1'b0, "R1");
    bdis(1'b0, 1, 1, 1'b0, "R1");
    // R2 zero length
    bdis(1'b0, 0, 0, 1'b0, "R2");
    // R3 clamp to reset limit 8
    bdis(1'b0, 20, 8, 1'b1, "R3");
    // R9 trusted limit write to 4
    @(negedge clk); trusted = 1'b1; lim_we = 1'b1; lim_val = 8'd4;
    @(negedge clk); trusted = 1'b0; lim_we = 1'b0;
    bdis(1'b0, 6, 4, 1'b1, "R9");
    // R9 untrusted write ignored
    @(negedge clk); lim_we = 1'b1; lim_val = 8'd10;
    @(negedge clk); lim_we = 1'b0;
    bdis(1'b0, 6, 4, 1'b1, "R9");
    // R8 trusted request is not clamped
    bdis(1'b1, 12, 12, 1'b0, "R8");

    // R4 nested request inside running window
    @(negedge clk);
    bdis_stb = 1'b1; bdis_len = 8'd4;
    for (int k = 1; k <= 4; k++) push(k, 1'b0, 1'b0, "R4");
    push(5, 1'b1, 1'b0, "R4");
    push(6, 1'b1, 1'b0, "R4");
    @(negedge clk); bdis_stb = 1'b0;
    @(negedge clk); bdis_stb = 1'b1; bdis_len = 8'd4;
    @(negedge clk); bdis_stb = 1'b0;
    idle(6);

    // R5 held request while interrupt pending; R4 second strobe during hold
    @(negedge clk);
    irq_pending = 1'b1; bdis_stb = 1'b1; bdis_len = 8'd3;
    for (int k = 1; k <= 5; k++) push(k, 1'b1, 1'b0, "R5");
    for (int k = 6; k <= 8; k++) push(k, 1'b0, 1'b0, "R5");
    push(9, 1'b1, 1'b0, "R5");
    push(10, 1'b1, 1'b0, "R4");
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      bdis_stb = (i == 2);
      bdis_len = 8'd4;
    end
    bdis_stb = 1'b0; irq_pending = 1'b0;
    idle(7);

    // R6 untrusted plain disable
    @(negedge clk); pdis_stb = 1'b1;
    push(1, 1'b1, 1'b1, "R6");
    push(2, 1'b1, 1'b0, "R6");
    @(negedge clk); pdis_stb = 1'b0;
    idle(3);

    // R7 trusted plain disable, untrusted enable ignored, trusted enable
    @(negedge clk); trusted = 1'b1; pdis_stb = 1'b1;
    push(1, 1'b0, 1'b0, "R7");
    push(30, 1'b0, 1'b0, "R7");
    push(32, 1'b0, 1'b0, "R7");
    push(34, 1'b1, 1'b0, "R7");
    @(negedge clk); trusted = 1'b0; pdis_stb = 1'b0;
    idle(29);
    pen_stb = 1'b1;                       // untrusted enable
    @(negedge clk); pen_stb = 1'b0;
    idle(1);
    trusted = 1'b1; pen_stb = 1'b1;       // trusted enable
    @(negedge clk); trusted = 1'b0; pen_stb = 1'b0;
    idle(4);

    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 %0d expectations never compared, expected 0", sb.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog expired, actual hung, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule